// File: doc/BRIEF.md
# Single-Slope ADC Charge Sequencer

This block holds one 8-bit control register on a CPU register bus and turns its contents into two pad controls for a single-slope analog-to-digital front end on a single analog pin: an enable for the charge current source and an enable for the discharge switch. A master enable bit gates both pad controls. A two-bit mode field chooses between manual operation and timer-synchronized operation. The remaining comparator-related bits are stored and read back, and nothing else.

The charge bit (bit 7) does two jobs. In manual mode software writes it to pick charging (1) or discharging (0). In a timer-synchronized mode the hardware also updates it. An output-compare pulse from the timer sets it, which starts a ramp. An input-capture pulse clears it, which ends the ramp and discharges the pin. A read always returns the live value of the bit.

Top module: `adc_slope_seq`

## Requirements
- R1: After a synchronous reset, the register reads 0x00, and both `chg_src_en` and `dis_sink_en` are 0.
- R2: A write with `bus_addr` equal to `REG_ADDR` (default 0x1D) loads all eight bits from `bus_wdata`. A read at that address returns them on `bus_rdata`. Any other address reads 0, and writes to it change nothing.
- R3: Bit 0 is the master enable. While it is 0, both pad outputs are 0, and timer pulses do not change the charge bit.
- R4: Bits 6:5 select the mode, and value 00 is manual mode. In manual mode with the master enable at 1, `chg_src_en` equals bit 7 and `dis_sink_en` equals its inverse. Bit 7 changes only when software writes it; timer pulses leave it unchanged.
- R5: In mode 11 with the master enable at 1, an `ocf_pulse` (with no `icf_pulse`) sets bit 7 at the next clock edge.
- R6: In mode 11 with the master enable at 1, an `icf_pulse` clears bit 7 at the next clock edge.
- R7: If `ocf_pulse` and `icf_pulse` arrive in the same cycle in an automatic mode, the clear wins and bit 7 becomes 0.
- R8: If a CPU write and a timer pulse that is acting on the bit arrive in the same cycle, the timer pulse decides bit 7. The other written bits are still loaded.
- R9: When parameter `PARTIAL_AUTO` is 1 (the default), modes 01 and 10 respond to timer pulses exactly as mode 11 does. When it is 0, they act as manual mode.
- R10: `chg_src_en` and `dis_sink_en` are never 1 at the same time.
- R11: A reset clears the mode bits during automatic operation, which returns the block to manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| ocf_pulse | input | 1 | Timer output-compare event, one cycle |
| icf_pulse | input | 1 | Timer input-capture event, one cycle |
| chg_src_en | output | 1 | Charge current source enable |
| dis_sink_en | output | 1 | Discharge switch enable |

## Verification
Each mode is driven with single output-compare pulses, single input-capture pulses, both pulses together, and pulses that coincide with CPU writes. This separates manual hold from hardware update, shows which event has priority, and shows whether the timer or the write wins. The same pulses are applied with the master enable cleared, and with writes to a different address, to show that the gate and the address decode block them. Modes 01 and 10 are run through the same set-and-clear sequence as mode 11. A reset during automatic mode confirms that the block returns to manual behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'b00,
        MODE_ALT_A  = 2'b01,
        MODE_ALT_B  = 2'b10,
        MODE_TIMER  = 2'b11
    } seq_mode_e;

    // Register layout, MSB first: charge, mode[1:0], capture enable,
    // comparator irq enable, comparator 2 enable, comparator 1 enable, master enable
    typedef struct packed {
        logic      chg;
        seq_mode_e mode;
        logic      cap_en;
        logic      cmp_irq_en;
        logic      cmp2_en;
        logic      cmp1_en;
        logic      master_en;
    } ctl_reg_t;

    function automatic logic mode_is_auto(seq_mode_e m, logic partial_auto);
        case (m)
            MODE_TIMER:             return 1'b1;
            MODE_ALT_A, MODE_ALT_B: return partial_auto;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
    import adc_seq_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h1D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              addr_hit,
    output logic              wr_hit,
    output ctl_reg_t          cfg_q
);
    ctl_reg_t wr_view;

    assign addr_hit = (bus_addr == REG_ADDR);
    assign wr_hit   = addr_hit && bus_wr;
    assign wr_view  = ctl_reg_t'(bus_wdata);

    // Bit 7 is held by the charge controller; this bank keeps the rest.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q     <= wr_view;
            cfg_q.chg <= 1'b0;
        end
    end

    p_mode_reset_r11: assert property (@(posedge clk)
        rst |=> (cfg_q.mode == MODE_MANUAL));

    p_no_stray_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg_q));
endmodule

// File: rtl/adc_chg_ctrl.sv
module adc_chg_ctrl
    import adc_seq_pkg::*;
#(
    parameter bit PARTIAL_AUTO = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  logic      wr_chg,
    input  ctl_reg_t  cfg_q,
    input  logic      ocf_pulse,
    input  logic      icf_pulse,
    output logic      chg_q
);
    logic hw_active;
    logic chg_d;

    assign hw_active = cfg_q.master_en && mode_is_auto(cfg_q.mode, PARTIAL_AUTO);

    always_comb begin
        chg_d = chg_q;
        if (wr_hit)
            chg_d = wr_chg;
        if (hw_active && icf_pulse)
            chg_d = 1'b0;
        else if (hw_active && ocf_pulse)
            chg_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) chg_q <= 1'b0;
        else     chg_q <= chg_d;
    end

    p_ocf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (hw_active && ocf_pulse && !icf_pulse) |=> chg_q);

    p_icf_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (hw_active && icf_pulse) |=> !chg_q);

    p_manual_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!hw_active && !wr_hit) |=> $stable(chg_q));

    p_event_over_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !wr_chg && hw_active && ocf_pulse && !icf_pulse) |=> chg_q);
endmodule

// File: rtl/adc_pad_drive.sv
module adc_pad_drive (
    input  logic clk,
    input  logic rst,
    input  logic master_en,
    input  logic chg,
    output logic src_en,
    output logic sink_en
);
    assign src_en  = master_en && chg;
    assign sink_en = master_en && !chg;

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(src_en && sink_en));

    p_isen_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> (!src_en && !sink_en));
endmodule

// File: rtl/adc_slope_seq.sv
module adc_slope_seq
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W       = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR     = 5'h1D,
    parameter bit                PARTIAL_AUTO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ocf_pulse,
    input  logic              icf_pulse,
    output logic              chg_src_en,
    output logic              dis_sink_en
);
    logic     addr_hit;
    logic     wr_hit;
    logic     chg_q;
    ctl_reg_t cfg_q;
    ctl_reg_t live;

    adc_ctl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .addr_hit(addr_hit), .wr_hit(wr_hit), .cfg_q(cfg_q)
    );

    adc_chg_ctrl #(.PARTIAL_AUTO(PARTIAL_AUTO)) u_chg (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_chg(bus_wdata[DATA_W-1]),
        .cfg_q(cfg_q), .ocf_pulse(ocf_pulse), .icf_pulse(icf_pulse), .chg_q(chg_q)
    );

    adc_pad_drive u_pad (
        .clk(clk), .rst(rst), .master_en(cfg_q.master_en), .chg(chg_q),
        .src_en(chg_src_en), .sink_en(dis_sink_en)
    );

    always_comb begin
        live     = cfg_q;
        live.chg = chg_q;
    end

    assign bus_rdata = addr_hit ? DATA_W'(live) : '0;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (chg_q == 1'b0 && cfg_q == '0));
endmodule

// File: tb/tb_adc_slope_seq.sv
module tb_adc_slope_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 22;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       ocf_pulse, icf_pulse;
    logic       chg_src_en, dis_sink_en;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_slope_seq dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ocf_pulse(ocf_pulse),
        .icf_pulse(icf_pulse), .chg_src_en(chg_src_en), .dis_sink_en(dis_sink_en)
    );

    // {wr, addr, wdata, ocf, icf, exp_rdata, exp_src, exp_sink}
    localparam logic [25:0] VEC [N_VEC] = '{
        {1'b1, 5'h1D, 8'h81, 1'b0, 1'b0, 8'h81, 1'b1, 1'b0}, // R4 manual charge
        {1'b1, 5'h1D, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1}, // R4 manual discharge
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1}, // R4 ocf ignored
        {1'b1, 5'h1D, 8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R3 gate off
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0}, // R3 icf ignored
        {1'b1, 5'h1D, 8'h61, 1'b0, 1'b0, 8'h61, 1'b0, 1'b1}, // R5 enter timer mode
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b0, 8'hE1, 1'b1, 1'b0}, // R5 ocf sets
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b0, 8'hE1, 1'b1, 1'b0}, // R5 holds
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b1, 8'h61, 1'b0, 1'b1}, // R6 icf clears
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b0, 8'hE1, 1'b1, 1'b0}, // R5 set again
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b1, 8'h61, 1'b0, 1'b1}, // R7 both: clear
        {1'b1, 5'h1D, 8'h61, 1'b1, 1'b0, 8'hE1, 1'b1, 1'b0}, // R8 ocf beats write
        {1'b1, 5'h1D, 8'hE1, 1'b0, 1'b1, 8'h61, 1'b0, 1'b1}, // R8 icf beats write
        {1'b1, 5'h1C, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R2 other address
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b0, 8'h61, 1'b0, 1'b1}, // R2 unchanged
        {1'b1, 5'h1D, 8'h3F, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b1}, // R2 mode 01 all bits
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b0, 8'hBF, 1'b1, 1'b0}, // R9 mode 01 ocf
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b1}, // R9 mode 01 icf
        {1'b1, 5'h1D, 8'h5E, 1'b0, 1'b0, 8'h5E, 1'b0, 1'b0}, // R3 mode 10 gated
        {1'b1, 5'h1D, 8'h5F, 1'b0, 1'b0, 8'h5F, 1'b0, 1'b1}, // R9 mode 10 on
        {1'b0, 5'h1D, 8'h00, 1'b1, 1'b0, 8'hDF, 1'b1, 1'b0}, // R9 mode 10 ocf
        {1'b0, 5'h1D, 8'h00, 1'b0, 1'b1, 8'h5F, 1'b0, 1'b1}  // R9 mode 10 icf
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got rdata=%02h src=%0b sink=%0b, expected rdata=%02h src=%0b sink=%0b",
                     req, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
        end
    endtask

    // Drive on negedge, let one posedge pass, sample on the next negedge.
    task automatic step(input logic wr, input logic [4:0] a, input logic [7:0] d,
                        input logic o, input logic i);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ocf_pulse = o; icf_pulse = i;
        @(negedge clk);
        bus_wr = 1'b0; ocf_pulse = 1'b0; icf_pulse = 1'b0;
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 5'h1D; bus_wdata = '0;
        ocf_pulse = 1'b0; icf_pulse = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {bus_rdata, chg_src_en, dis_sink_en}, 10'h000);

        for (int k = 0; k < N_VEC; k++) begin
            logic [25:0] v;
            v = VEC[k];
            bus_wr = v[25]; bus_addr = v[24:20]; bus_wdata = v[19:12];
            ocf_pulse = v[11]; icf_pulse = v[10];
            @(negedge clk);
            check($sformatf("R2-vector %0d", k), {bus_rdata, chg_src_en, dis_sink_en}, v[9:0]);
            total++;
            if (chg_src_en && dis_sink_en) begin
                bad++;
                $display("FAIL R10 vector %0d: got src=1 sink=1, expected not both", k);
            end
            bus_wr = 1'b0; ocf_pulse = 1'b0; icf_pulse = 1'b0;
        end

        // R11: reset during timer mode with charge set
        step(1'b1, 5'h1D, 8'hE1, 1'b0, 1'b0);
        check("R11 pre-reset charge", {bus_rdata, chg_src_en, dis_sink_en}, {8'hE1, 2'b10});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 R1 after reset", {bus_rdata, chg_src_en, dis_sink_en}, 10'h000);
        step(1'b1, 5'h1D, 8'h01, 1'b0, 1'b0);
        step(1'b0, 5'h1D, 8'h00, 1'b1, 1'b0);
        check("R11 manual after reset, ocf ignored", {bus_rdata, chg_src_en, dis_sink_en},
              {8'h01, 2'b01});
        step(1'b1, 5'h1D, 8'h81, 1'b0, 1'b1);
        check("R4 manual write with icf", {bus_rdata, chg_src_en, dis_sink_en}, {8'h81, 2'b10});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule